// File: doc/BRIEF.md
# Counter Configuration Access Trap Checker

This unit decides, for a coprocessor-style read or write aimed at one of the per-counter event configuration registers, what the processor must do with the access. It sees the access encoding, the direction, the current privilege level, which levels run the narrow 32-bit state, and the enable and trap controls owned by levels 1, 2 and 3. From these it picks one of five outcomes: perform the access, hide it (a read gives zero and a write is dropped), raise an undefined-instruction fault, trap to a named level with a syndrome code, or report the constrained-unpredictable case. The configuration registers are not in this block. It only makes the decision.

The counter number comes from two encoding fields. The two low bits of CRm supply the upper part and the three-bit opc2 field supplies the lower part. The number is checked against two limits: the count of counters that are built, and the smaller count that the hypervisor leaves open to lower levels. Checks are taken in a fixed order of priority, so when several conditions hold at once, the first one in that order sets the outcome. A request strobe is answered exactly one cycle later by a done pulse and the registered result.

Top module: `ctr_trap_chk`

## Requirements
- R1: The counter number is `{crm_lo, opc2}` (0 to 31). If it is equal to or above `impl_cnt`, the outcome is undefined when `fgt_impl` is 1 and unpredictable when `fgt_impl` is 0. This check comes before every other check.
- R2: At levels 0 to 2, if level 3 is present and wide, `l3_tpm` is 1 and `sdd_undef_prio` is 1, the outcome is undefined. This is checked ahead of R3 to R9.
- R3: At level 0 with a wide level 1, the access is refused when `usr_en` is 0 and `usr_ext_en` is not enabled by `ext_user_impl`. A refusal traps with syndrome 0x03. The target is level 2 when level 2 is active, wide and has `l2_tge` set. Otherwise the target is level 1.
- R4: At level 0 with a narrow level 1 and `usr_en` equal to 0, the outcome is as follows. With `l2_tge` set and level 2 active, it traps to level 2, with syndrome 0x03 if level 2 is wide and 0x00 if level 2 is narrow. In every other case it is undefined.
- R5: At level 0, a fine-grained trap bit traps to level 2 with syndrome 0x03. The bit is `fgt_wr_trap` for a write and `fgt_rd_trap` for a read. This applies only when all of these hold: level 2 is active, level 1 is wide, `host_mode` is 0, `fgt_impl` is 1, and level 3 is either absent or has `l3_fgt_allow` set.
- R6: At levels 0 and 1, with level 2 active, `l2_tpm` traps to level 2 with syndrome 0x03.
- R7: At levels 0 and 1, with level 2 active and the counter number equal to or above `acc_cnt`, the access traps to level 2 with syndrome 0x03 when `fgt_impl` is 1. When `fgt_impl` is 0 the outcome is unpredictable.
- R8: At levels 0 to 2, with level 3 present and wide, `l3_tpm` traps to level 3 with syndrome 0x03. When `sdd_undef` is 1 the outcome is undefined instead.
- R9: At level 0 with a wide level 1, `ext_user_impl` and `usr_ext_en` both set, the access is hidden in two cases. A read is hidden when bit `usr_acc[idx]` is 0. A write is hidden when that bit is 0 or when `usr_ro` is 1.
- R10: An in-range access at level 3 is always performed. At any level, an access that no rule above catches is performed.
- R11: `done` is high exactly in the cycle after a `req` cycle. `res_kind` is one-hot with bit 0 = perform, bit 1 = hide, bit 2 = undefined, bit 3 = trap, bit 4 = unpredictable. `res_lvl` and `res_syn` are zero unless the outcome is a trap. When `done` is low, all result outputs are zero.
- R12: While `rst` is high, and in the first cycle after it, `done`, `res_kind`, `res_lvl` and `res_syn` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| crm_lo | input | 2 | Low bits of CRm, upper counter-number bits |
| opc2 | input | 3 | opc2 field, lower counter-number bits |
| cur_lvl | input | 2 | Current privilege level 0 to 3 |
| l1_narrow | input | 1 | Level 1 runs the 32-bit state |
| l2_narrow | input | 1 | Level 2 runs the 32-bit state |
| l3_narrow | input | 1 | Level 3 runs the 32-bit state |
| l2_active | input | 1 | Level 2 enabled in current security state |
| l3_present | input | 1 | Level 3 implemented |
| host_mode | input | 1 | Level 0 runs under a host-mode level 2 |
| fgt_impl | input | 1 | Fine-grained trap feature present |
| ext_user_impl | input | 1 | Extended user-enable feature present |
| usr_en | input | 1 | User access enable |
| usr_ext_en | input | 1 | Extended per-counter user enable |
| usr_ro | input | 1 | User event-read-only control |
| usr_acc | input | 32 | Per-counter user access bits |
| l2_tge | input | 1 | Level 2 redirects level-0 exceptions |
| l2_tpm | input | 1 | Level 2 monitor-access trap |
| l3_tpm | input | 1 | Level 3 monitor-access trap |
| l3_fgt_allow | input | 1 | Level 3 allows fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained read trap for these registers |
| fgt_wr_trap | input | 1 | Fine-grained write trap for these registers |
| sdd_undef | input | 1 | Secure-debug-disable gives undefined at R8 |
| sdd_undef_prio | input | 1 | Prioritised secure-debug-disable condition |
| impl_cnt | input | 6 | Number of counters implemented |
| acc_cnt | input | 6 | Number of counters open to levels 0 and 1 |
| done | output | 1 | Result valid pulse |
| res_kind | output | 5 | One-hot outcome |
| res_lvl | output | 2 | Trap target level |
| res_syn | output | 8 | Trap syndrome code |

## Verification
Many checks in the chain can fire on the same access. The cases that matter most are these: the prioritised secure-debug undefined against a user-enable refusal or a level-2 monitor trap, a fine-grained trap against the level-2 monitor bit, and the accessible-count trap against the per-counter hide condition. Random stimulus sets the trap and enable bits with a bias toward many bits set at once, and directed cases arm two competing conditions together. Each result is compared on every clock with a behavioural reference that walks the priority order and gives back the requirement that decided the outcome.

// File: rtl/ctr_trap_pkg.sv
package ctr_trap_pkg;
    localparam int IDX_W = 5;
    localparam int CNT_W = IDX_W + 1;
    localparam int NCTR  = 1 << IDX_W;
    localparam int SYN_W = 8;
    localparam int OC_W  = 5;

    localparam logic [1:0] LVL_USR = 2'd0;
    localparam logic [1:0] LVL_OS  = 2'd1;
    localparam logic [1:0] LVL_HYP = 2'd2;
    localparam logic [1:0] LVL_MON = 2'd3;

    localparam logic [SYN_W-1:0] SYN_SYSREG  = 8'h03;
    localparam logic [SYN_W-1:0] SYN_UNKNOWN = 8'h00;

    typedef enum logic [OC_W-1:0] {
        OC_NONE   = 5'b00000,
        OC_DO     = 5'b00001,
        OC_HIDE   = 5'b00010,
        OC_UNDEF  = 5'b00100,
        OC_TRAP   = 5'b01000,
        OC_UNPRED = 5'b10000
    } outcome_e;

    typedef struct packed {
        outcome_e         oc;
        logic [1:0]       lvl;
        logic [SYN_W-1:0] syn;
    } verdict_t;

    function automatic verdict_t plain(outcome_e oc);
        verdict_t v;
        v.oc  = oc;
        v.lvl = '0;
        v.syn = '0;
        return v;
    endfunction

    function automatic verdict_t trap_to(logic [1:0] lvl, logic [SYN_W-1:0] syn);
        verdict_t v;
        v.oc  = OC_TRAP;
        v.lvl = lvl;
        v.syn = syn;
        return v;
    endfunction
endpackage

// File: rtl/ctr_idx_decode.sv
module ctr_idx_decode
    import ctr_trap_pkg::*;
(
    input  logic [1:0]       crm_lo,
    input  logic [2:0]       opc2,
    input  logic [CNT_W-1:0] impl_cnt,
    input  logic [CNT_W-1:0] acc_cnt,
    output logic [IDX_W-1:0] idx,
    output logic             over_impl,
    output logic             over_acc
);
    logic [CNT_W-1:0] idx_ext;

    assign idx       = {crm_lo, opc2};
    assign idx_ext   = {1'b0, idx};
    assign over_impl = idx_ext >= impl_cnt;
    assign over_acc  = idx_ext >= acc_cnt;
endmodule

// File: rtl/ctr_user_gate.sv
module ctr_user_gate
    import ctr_trap_pkg::*;
(
    input  logic             req_wr,
    input  logic [IDX_W-1:0] idx,
    input  logic             l1_narrow,
    input  logic             l2_narrow,
    input  logic             l2_active,
    input  logic             l3_present,
    input  logic             host_mode,
    input  logic             fgt_impl,
    input  logic             ext_user_impl,
    input  logic             usr_en,
    input  logic             usr_ext_en,
    input  logic             usr_ro,
    input  logic [NCTR-1:0]  usr_acc,
    input  logic             l2_tge,
    input  logic             l3_fgt_allow,
    input  logic             fgt_rd_trap,
    input  logic             fgt_wr_trap,
    output logic             refuse,
    output verdict_t         refuse_v,
    output logic             fgt_hit,
    output logic             hide
);
    logic ext_on;
    logic wide_ok;
    logic redirect_wide;
    logic redirect_narrow;
    logic fgt_sel;

    assign ext_on          = ext_user_impl & usr_ext_en & ~l1_narrow;
    assign wide_ok         = usr_en | (ext_user_impl & usr_ext_en);
    assign redirect_wide   = l2_active & ~l2_narrow & l2_tge;
    assign redirect_narrow = l2_active & l2_narrow & l2_tge;
    assign fgt_sel         = req_wr ? fgt_wr_trap : fgt_rd_trap;

    assign refuse = l1_narrow ? ~usr_en : ~wide_ok;

    always_comb begin
        if (!l1_narrow) begin
            refuse_v = trap_to(redirect_wide ? LVL_HYP : LVL_OS, SYN_SYSREG);
        end else if (redirect_wide) begin
            refuse_v = trap_to(LVL_HYP, SYN_SYSREG);
        end else if (redirect_narrow) begin
            refuse_v = trap_to(LVL_HYP, SYN_UNKNOWN);
        end else begin
            refuse_v = plain(OC_UNDEF);
        end
    end

    assign fgt_hit = l2_active & ~l1_narrow & ~host_mode & fgt_impl
                   & (~l3_present | l3_fgt_allow) & fgt_sel;

    assign hide = ext_on & (~usr_acc[idx] | (req_wr & usr_ro));
endmodule

// File: rtl/ctr_trap_resolve.sv
module ctr_trap_resolve
    import ctr_trap_pkg::*;
(
    input  logic [1:0] cur_lvl,
    input  logic       over_impl,
    input  logic       over_acc,
    input  logic       fgt_impl,
    input  logic       l2_active,
    input  logic       l3_present,
    input  logic       l3_narrow,
    input  logic       l2_tpm,
    input  logic       l3_tpm,
    input  logic       sdd_undef,
    input  logic       sdd_undef_prio,
    input  logic       refuse,
    input  verdict_t   refuse_v,
    input  logic       fgt_hit,
    input  logic       hide,
    output verdict_t   verdict
);
    logic is_usr;
    logic below_hyp;
    logic mon_trap;

    assign is_usr    = cur_lvl == LVL_USR;
    assign below_hyp = (cur_lvl == LVL_USR) | (cur_lvl == LVL_OS);
    assign mon_trap  = l3_present & ~l3_narrow & l3_tpm;

    always_comb begin
        if (over_impl) begin
            verdict = plain(fgt_impl ? OC_UNDEF : OC_UNPRED);
        end else if (cur_lvl == LVL_MON) begin
            verdict = plain(OC_DO);
        end else if (mon_trap && sdd_undef_prio) begin
            verdict = plain(OC_UNDEF);
        end else if (is_usr && refuse) begin
            verdict = refuse_v;
        end else if (is_usr && fgt_hit) begin
            verdict = trap_to(LVL_HYP, SYN_SYSREG);
        end else if (below_hyp && l2_active && l2_tpm) begin
            verdict = trap_to(LVL_HYP, SYN_SYSREG);
        end else if (below_hyp && l2_active && over_acc) begin
            verdict = fgt_impl ? trap_to(LVL_HYP, SYN_SYSREG) : plain(OC_UNPRED);
        end else if (mon_trap) begin
            verdict = sdd_undef ? plain(OC_UNDEF) : trap_to(LVL_MON, SYN_SYSREG);
        end else if (is_usr && hide) begin
            verdict = plain(OC_HIDE);
        end else begin
            verdict = plain(OC_DO);
        end
    end
endmodule

// File: rtl/ctr_trap_chk.sv
module ctr_trap_chk
    import ctr_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_wr,
    input  logic [1:0]       crm_lo,
    input  logic [2:0]       opc2,
    input  logic [1:0]       cur_lvl,
    input  logic             l1_narrow,
    input  logic             l2_narrow,
    input  logic             l3_narrow,
    input  logic             l2_active,
    input  logic             l3_present,
    input  logic             host_mode,
    input  logic             fgt_impl,
    input  logic             ext_user_impl,
    input  logic             usr_en,
    input  logic             usr_ext_en,
    input  logic             usr_ro,
    input  logic [31:0]      usr_acc,
    input  logic             l2_tge,
    input  logic             l2_tpm,
    input  logic             l3_tpm,
    input  logic             l3_fgt_allow,
    input  logic             fgt_rd_trap,
    input  logic             fgt_wr_trap,
    input  logic             sdd_undef,
    input  logic             sdd_undef_prio,
    input  logic [5:0]       impl_cnt,
    input  logic [5:0]       acc_cnt,
    output logic             done,
    output logic [4:0]       res_kind,
    output logic [1:0]       res_lvl,
    output logic [7:0]       res_syn
);
    logic [IDX_W-1:0] idx;
    logic             over_impl;
    logic             over_acc;
    logic             refuse;
    verdict_t         refuse_v;
    logic             fgt_hit;
    logic             hide;
    verdict_t         verdict;
    verdict_t         held;
    logic             done_q;

    ctr_idx_decode i_decode (
        .crm_lo   (crm_lo),
        .opc2     (opc2),
        .impl_cnt (impl_cnt),
        .acc_cnt  (acc_cnt),
        .idx      (idx),
        .over_impl(over_impl),
        .over_acc (over_acc)
    );

    ctr_user_gate i_gate (
        .req_wr       (req_wr),
        .idx          (idx),
        .l1_narrow    (l1_narrow),
        .l2_narrow    (l2_narrow),
        .l2_active    (l2_active),
        .l3_present   (l3_present),
        .host_mode    (host_mode),
        .fgt_impl     (fgt_impl),
        .ext_user_impl(ext_user_impl),
        .usr_en       (usr_en),
        .usr_ext_en   (usr_ext_en),
        .usr_ro       (usr_ro),
        .usr_acc      (usr_acc),
        .l2_tge       (l2_tge),
        .l3_fgt_allow (l3_fgt_allow),
        .fgt_rd_trap  (fgt_rd_trap),
        .fgt_wr_trap  (fgt_wr_trap),
        .refuse       (refuse),
        .refuse_v     (refuse_v),
        .fgt_hit      (fgt_hit),
        .hide         (hide)
    );

    ctr_trap_resolve i_resolve (
        .cur_lvl       (cur_lvl),
        .over_impl     (over_impl),
        .over_acc      (over_acc),
        .fgt_impl      (fgt_impl),
        .l2_active     (l2_active),
        .l3_present    (l3_present),
        .l3_narrow     (l3_narrow),
        .l2_tpm        (l2_tpm),
        .l3_tpm        (l3_tpm),
        .sdd_undef     (sdd_undef),
        .sdd_undef_prio(sdd_undef_prio),
        .refuse        (refuse),
        .refuse_v      (refuse_v),
        .fgt_hit       (fgt_hit),
        .hide          (hide),
        .verdict       (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            held   <= plain(OC_NONE);
        end else begin
            done_q <= req;
            held   <= req ? verdict : plain(OC_NONE);
        end
    end

    assign done     = done_q;
    assign res_kind = held.oc;
    assign res_lvl  = held.lvl;
    assign res_syn  = held.syn;
endmodule

// File: rtl/ctr_trap_chk_sva.sv
module ctr_trap_chk_sva (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic [1:0] crm_lo,
    input logic [2:0] opc2,
    input logic [1:0] cur_lvl,
    input logic       fgt_impl,
    input logic [5:0] impl_cnt,
    input logic       done,
    input logic [4:0] res_kind,
    input logic [1:0] res_lvl,
    input logic [7:0] res_syn
);
    logic in_range;
    assign in_range = {1'b0, crm_lo, opc2} < impl_cnt;

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> done); // R11
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req |=> !done); // R11
    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones(res_kind) == 1); // R11
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> (res_kind == 5'd0 && res_lvl == 2'd0 && res_syn == 8'd0)); // R11
    AST_CLEAN_NON_TRAP: assert property (@(posedge clk) disable iff (rst)
        (done && res_kind != 5'b01000) |-> (res_lvl == 2'd0 && res_syn == 8'd0)); // R11
    AST_OOR_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (req && !in_range && fgt_impl) |=> res_kind == 5'b00100); // R1
    AST_OOR_UNPRED: assert property (@(posedge clk) disable iff (rst)
        (req && !in_range && !fgt_impl) |=> res_kind == 5'b10000); // R1
    AST_TOP_LEVEL_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (req && in_range && cur_lvl == 2'd3) |=> res_kind == 5'b00001); // R10
endmodule

bind ctr_trap_chk ctr_trap_chk_sva i_sva (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .crm_lo  (crm_lo),
    .opc2    (opc2),
    .cur_lvl (cur_lvl),
    .fgt_impl(fgt_impl),
    .impl_cnt(impl_cnt),
    .done    (done),
    .res_kind(res_kind),
    .res_lvl (res_lvl),
    .res_syn (res_syn)
);

// File: tb/test_ctr_trap_chk.sv
`timescale 1ns/1ps
module test_ctr_trap_chk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [1:0]  crm_lo = '0;
    logic [2:0]  opc2 = '0;
    logic [1:0]  cur_lvl = '0;
    logic        l1_narrow = 0, l2_narrow = 0, l3_narrow = 0;
    logic        l2_active = 0, l3_present = 0, host_mode = 0;
    logic        fgt_impl = 0, ext_user_impl = 0;
    logic        usr_en = 0, usr_ext_en = 0, usr_ro = 0;
    logic [31:0] usr_acc = '0;
    logic        l2_tge = 0, l2_tpm = 0, l3_tpm = 0, l3_fgt_allow = 0;
    logic        fgt_rd_trap = 0, fgt_wr_trap = 0;
    logic        sdd_undef = 0, sdd_undef_prio = 0;
    logic [5:0]  impl_cnt = '0, acc_cnt = '0;
    logic        done;
    logic [4:0]  res_kind;
    logic [1:0]  res_lvl;
    logic [7:0]  res_syn;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic       d;
        logic [4:0] k;
        logic [1:0] l;
        logic [7:0] s;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    ctr_trap_chk i_ctr_trap_chk (.*);

    // Behavioural reference: walks the priority order and names the deciding rule.
    function automatic exp_t model();
        exp_t e;
        int n;
        e.d = 1'b1; e.k = 5'b00001; e.l = 2'd0; e.s = 8'd0; e.tag = "R10";
        n = int'(crm_lo) * 8 + int'(opc2);
        if (n >= int'(impl_cnt)) begin
            e.tag = "R1";
            e.k = fgt_impl ? 5'b00100 : 5'b10000;
            return e;
        end
        if (cur_lvl == 2'd3) return e;
        if (l3_present && !l3_narrow && l3_tpm && sdd_undef_prio) begin
            e.tag = "R2"; e.k = 5'b00100; return e;
        end
        if (cur_lvl == 2'd0) begin
            if (!l1_narrow && !(usr_en || (ext_user_impl && usr_ext_en))) begin
                e.tag = "R3"; e.k = 5'b01000; e.s = 8'h03;
                e.l = (l2_active && !l2_narrow && l2_tge) ? 2'd2 : 2'd1;
                return e;
            end
            if (l1_narrow && !usr_en) begin
                e.tag = "R4";
                if (l2_active && l2_tge) begin
                    e.k = 5'b01000; e.l = 2'd2; e.s = l2_narrow ? 8'h00 : 8'h03;
                end else begin
                    e.k = 5'b00100;
                end
                return e;
            end
            if (l2_active && !l1_narrow && !host_mode && fgt_impl &&
                (!l3_present || l3_fgt_allow) && (req_wr ? fgt_wr_trap : fgt_rd_trap)) begin
                e.tag = "R5"; e.k = 5'b01000; e.l = 2'd2; e.s = 8'h03; return e;
            end
        end
        if (cur_lvl < 2'd2 && l2_active && l2_tpm) begin
            e.tag = "R6"; e.k = 5'b01000; e.l = 2'd2; e.s = 8'h03; return e;
        end
        if (cur_lvl < 2'd2 && l2_active && n >= int'(acc_cnt)) begin
            e.tag = "R7";
            if (fgt_impl) begin e.k = 5'b01000; e.l = 2'd2; e.s = 8'h03; end
            else e.k = 5'b10000;
            return e;
        end
        if (l3_present && !l3_narrow && l3_tpm) begin
            e.tag = "R8";
            if (sdd_undef) e.k = 5'b00100;
            else begin e.k = 5'b01000; e.l = 2'd3; e.s = 8'h03; end
            return e;
        end
        if (cur_lvl == 2'd0 && ext_user_impl && !l1_narrow && usr_ext_en &&
            (!usr_acc[n] || (req_wr && usr_ro))) begin
            e.tag = "R9"; e.k = 5'b00010; return e;
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        compared++;
        if (done !== e.d || res_kind !== e.k || res_lvl !== e.l || res_syn !== e.s) begin
            mismatched++;
            $display("FAIL %s actual done=%b kind=%b lvl=%0d syn=%h expected done=%b kind=%b lvl=%0d syn=%h",
                     e.tag, done, res_kind, res_lvl, res_syn, e.d, e.k, e.l, e.s);
        end
    endtask

    // One clock: check last cycle's result, then drive the request set up by the caller.
    task automatic step(input logic fire);
        exp_t e;
        if (expq.size() > 0) compare(expq.pop_front());
        req = fire;
        if (fire) e = model();
        else begin e.d = 0; e.k = 0; e.l = 0; e.s = 0; e.tag = "R11"; end
        expq.push_back(e);
        @(negedge clk);
    endtask

    task automatic base();
        req_wr = 0; crm_lo = 2'd0; opc2 = 3'd2; cur_lvl = 2'd0;
        l1_narrow = 0; l2_narrow = 0; l3_narrow = 0;
        l2_active = 1; l3_present = 1; host_mode = 0;
        fgt_impl = 1; ext_user_impl = 1;
        usr_en = 1; usr_ext_en = 0; usr_ro = 0; usr_acc = '1;
        l2_tge = 0; l2_tpm = 0; l3_tpm = 0; l3_fgt_allow = 1;
        fgt_rd_trap = 0; fgt_wr_trap = 0; sdd_undef = 0; sdd_undef_prio = 0;
        impl_cnt = 6'd31; acc_cnt = 6'd31;
    endtask

    function automatic logic pick(int n);
        return $urandom_range(n - 1, 0) == 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        base();
        repeat (3) @(negedge clk);
        // R12: outputs zero during reset
        compared++;
        if (done !== 0 || res_kind !== 0 || res_lvl !== 0 || res_syn !== 0) begin
            mismatched++;
            $display("FAIL R12 actual done=%b kind=%b lvl=%0d syn=%h expected all zero",
                     done, res_kind, res_lvl, res_syn);
        end
        rst = 1'b0;
        @(negedge clk);
        // R12: first cycle after reset still idle
        compared++;
        if (done !== 0 || res_kind !== 0) begin
            mismatched++;
            $display("FAIL R12 actual done=%b kind=%b expected done=0 kind=0", done, res_kind);
        end

        // R1: index 31 above implemented count, with and without fine-grained feature
        base(); crm_lo = 2'd3; opc2 = 3'd7; impl_cnt = 6'd20; step(1);
        fgt_impl = 0; step(1);
        base(); crm_lo = 2'd2; opc2 = 3'd3; impl_cnt = 6'd19; step(1);
        // R2: prioritised secure-debug undefined ahead of level-2 monitor trap
        base(); cur_lvl = 2'd1; l3_tpm = 1; sdd_undef_prio = 1; l2_tpm = 1; step(1);
        base(); cur_lvl = 2'd0; usr_en = 0; l3_tpm = 1; sdd_undef_prio = 1; step(1);
        // R3: wide level-1 refusal, redirected and not
        base(); usr_en = 0; l2_tge = 1; step(1);
        l2_tge = 0; step(1);
        // R4: narrow level-1 refusal variants
        base(); l1_narrow = 1; usr_en = 0; l2_narrow = 1; l2_tge = 1; step(1);
        l2_narrow = 0; step(1);
        l2_tge = 0; step(1);
        // R5: fine-grained read trap, write unaffected, host mode masks it
        base(); fgt_rd_trap = 1; l2_tpm = 1; step(1);
        base(); fgt_rd_trap = 1; req_wr = 1; step(1);
        base(); fgt_wr_trap = 1; req_wr = 1; host_mode = 1; step(1);
        // R6: level-2 monitor trap at level 1
        base(); cur_lvl = 2'd1; l2_tpm = 1; step(1);
        // R7: accessible limit, trap and unpredictable
        base(); cur_lvl = 2'd1; crm_lo = 2'd1; opc2 = 3'd2; acc_cnt = 6'd8; step(1);
        fgt_impl = 0; step(1);
        base(); cur_lvl = 2'd2; crm_lo = 2'd1; acc_cnt = 6'd4; step(1);
        // R8: level-3 monitor trap from level 2, then undefined form
        base(); cur_lvl = 2'd2; l3_tpm = 1; step(1);
        sdd_undef = 1; step(1);
        // R9: hide read and write, then write blocked by read-only
        base(); usr_en = 0; usr_ext_en = 1; usr_acc = ~32'h4; step(1);
        req_wr = 1; step(1);
        usr_acc = '1; usr_ro = 1; step(1);
        usr_ro = 0; step(1);
        // R9 against R7: accessible-count trap wins over hide
        base(); usr_ext_en = 1; usr_acc = '0; acc_cnt = 6'd1; step(1);
        // R10: level 3 ignores every trap control
        base(); cur_lvl = 2'd3; l2_tpm = 1; l3_tpm = 1; sdd_undef_prio = 1; usr_en = 0; step(1);
        // R11: idle gap then back-to-back requests
        step(0); step(0);
        base(); step(1); cur_lvl = 2'd1; step(1); step(0);

        // Random phase with bias toward several controls active together
        for (int i = 0; i < 4000; i++) begin
            req_wr = pick(2); crm_lo = 2'($urandom); opc2 = 3'($urandom);
            cur_lvl = 2'($urandom);
            l1_narrow = pick(3); l2_narrow = pick(3); l3_narrow = pick(4);
            l2_active = !pick(4); l3_present = !pick(4); host_mode = pick(5);
            fgt_impl = !pick(3); ext_user_impl = !pick(3);
            usr_en = !pick(2); usr_ext_en = pick(2); usr_ro = pick(3);
            usr_acc = $urandom;
            l2_tge = pick(3); l2_tpm = pick(5); l3_tpm = pick(5); l3_fgt_allow = !pick(3);
            fgt_rd_trap = pick(4); fgt_wr_trap = pick(4);
            sdd_undef = pick(3); sdd_undef_prio = pick(6);
            impl_cnt = 6'($urandom_range(32, 0)); acc_cnt = 6'($urandom_range(32, 0));
            step(!pick(5));
        end
        step(0);
        if (expq.size() > 0) compare(expq.pop_front());

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule